// File: doc/BRIEF.md
# Dual-Enable Card Bus Lane Steering

This block sits between the pins of a removable memory card with a 16-bit host data bus and a 16-bit internal memory port. Each clock it samples the two active-low card enables, the space select, the output and write enables, address bit zero and the host data bus into one register stage. From that sample it works out the access width and the byte lane. It drives a separate output enable for the low and the high data byte, and it routes the internal read word onto the correct lanes.

On the rising edge of the write enable, it turns the host write into one transfer on the internal port. That transfer carries per-byte strobes, a space flag and a word already placed in the right byte positions.

The space select picks common memory (high) or attribute memory (low). Attribute memory is a byte-wide store that is reached on the low lane only. A build parameter says whether attribute memory is fitted. When it is not fitted, attribute reads return a fixed fill byte and attribute writes are dropped.

The internal write port is valid/ready. Once `wr_valid` rises, the payload stays frozen until a cycle with `wr_ready` high. Any host write edge that arrives while a transfer is still waiting is discarded.

Top module: `card_lane_steer`

## Requirements
- R1: In reset and in the first cycle after it, both lane output enables are low and `wr_valid` is low.
- R2: With both card enables high (standby), neither lane output enable is asserted, whatever the other pins do.
- R3: CE1 low with CE2 high is 8-bit mode. Only the low lane is driven. For common memory it carries `mem_rdata[7:0]` when A0=0 and `mem_rdata[15:8]` when A0=1.
- R4: Both enables low is 16-bit mode. Both lanes are driven with `mem_rdata[7:0]` on bits 7:0 and `mem_rdata[15:8]` on bits 15:8, and A0 has no effect.
- R5: CE1 high with CE2 low is odd-byte mode. Only the high lane is driven, with `mem_rdata[15:8]`, and A0 has no effect.
- R6: A lane is driven only when OE is low and WE is high. In 8-bit and odd-byte modes the two lane enables are never both high.
- R7: For an attribute read, the low lane carries `mem_rdata[7:0]` in 16-bit mode and at even addresses in 8-bit mode. The fill byte (FFh by default) appears at odd addresses in 8-bit mode and on the high lane. `mem_attr_sel` is high while the sampled space select is low.
- R8: With `ATTR_FITTED=0`, every attribute read returns the fill byte on each lane that is driven.
- R9: When WE rises while OE is high and a card enable is low, one common write is issued, with `wr_strb` bit0 = even byte and bit1 = odd byte. 8-bit mode gives strobe 01 (A0=0) or 10 (A0=1) with the low lane copied to both halves. 16-bit mode gives 11 with the data word as sampled. Odd-byte mode gives 10 with the high lane copied to both halves.
- R10: An attribute write gives strobe 01, `wr_attr`=1 and the low lane copied to both halves, in 16-bit mode or in 8-bit mode at A0=0. Attribute writes at odd 8-bit addresses, in odd-byte mode, or with `ATTR_FITTED=0` produce no transfer.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_strb`, `wr_attr` and `wr_data` hold. Host write edges arriving then are dropped.
- R12: A pin change becomes visible on the outputs after exactly one rising clock edge. A write transfer appears after the edge at which the new high WE is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_ce1_n | input | 1 | Card enable for the even/low side, active low |
| host_ce2_n | input | 1 | Card enable for the odd/high side, active low |
| host_reg_n | input | 1 | Space select: high common, low attribute |
| host_oe_n | input | 1 | Output enable, active low |
| host_we_n | input | 1 | Write enable, active low |
| host_a0 | input | 1 | Address bit zero |
| host_dq_in | input | 16 | Data from host bus |
| host_dq_out | output | 16 | Data toward host bus |
| host_dq_oe_lo | output | 1 | Drive enable for bits 7:0 |
| host_dq_oe_hi | output | 1 | Drive enable for bits 15:8 |
| mem_attr_sel | output | 1 | Internal port targets attribute space |
| mem_rdata | input | 16 | Read word from internal memory |
| wr_valid | output | 1 | Write transfer pending |
| wr_ready | input | 1 | Internal port accepts the transfer |
| wr_attr | output | 1 | Transfer goes to attribute space |
| wr_strb | output | 2 | Byte strobes, bit0 even, bit1 odd |
| wr_data | output | 16 | Write word, bytes placed per strobe |

## Verification
The bench builds two copies side by side on the same pins. One keeps the defaults (8-bit lanes, attribute memory fitted, fill FFh). The other sets `ATTR_FITTED=0`, so the fill path and the dropped attribute writes can be checked against the fitted behaviour under identical stimulus. Holding `wr_ready` low by default makes the back-pressure hold and the dropping of a second write edge observable at the ports.

// File: rtl/card_lane_pkg.sv
package card_lane_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_WIDE   = 2'd2,
    MODE_UPPER  = 2'd3
  } bus_mode_e;

  typedef struct packed {
    logic        ce1_n;
    logic        ce2_n;
    logic        reg_n;
    logic        oe_n;
    logic        we_n;
    logic        a0;
    logic [15:0] data;
  } pin_sample_t;
endpackage

// File: rtl/lane_mode_dec.sv
module lane_mode_dec
  import card_lane_pkg::*;
(
  input  logic      ce1_n,
  input  logic      ce2_n,
  output bus_mode_e mode
);
  always_comb begin
    unique case ({ce1_n, ce2_n})
      2'b01:   mode = MODE_NARROW;
      2'b00:   mode = MODE_WIDE;
      2'b10:   mode = MODE_UPPER;
      default: mode = MODE_IDLE;
    endcase
  end
endmodule

// File: rtl/lane_read_mux.sv
module lane_read_mux
  import card_lane_pkg::*;
#(
  parameter int          LANE_W      = 8,
  parameter bit          ATTR_FITTED = 1'b1,
  parameter logic [7:0]  FILL_BYTE   = 8'hFF,
  localparam int         WORD_W      = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_mode_e         mode,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              reg_n,
  input  logic              a0,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] dq_out,
  output logic              oe_lo,
  output logic              oe_hi
);
  localparam logic [LANE_W-1:0] FILL = LANE_W'(FILL_BYTE);

  logic              drive;
  logic [LANE_W-1:0] rd_lo, rd_hi, out_lo, out_hi;

  assign rd_lo = rdata[LANE_W-1:0];
  assign rd_hi = rdata[WORD_W-1:LANE_W];
  assign drive = !oe_n && we_n && (mode != MODE_IDLE);
  assign oe_lo = drive && (mode == MODE_NARROW || mode == MODE_WIDE);
  assign oe_hi = drive && (mode == MODE_WIDE || mode == MODE_UPPER);

  always_comb begin
    if (reg_n) begin
      out_lo = (mode == MODE_NARROW && a0) ? rd_hi : rd_lo;
      out_hi = rd_hi;
    end else begin
      out_lo = (ATTR_FITTED && !(mode == MODE_NARROW && a0)) ? rd_lo : FILL;
      out_hi = FILL;
    end
  end
  assign dq_out = {out_hi, out_lo};

  p_quiet_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE) |-> (!oe_lo && !oe_hi));
  p_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_WIDE) |-> !(oe_lo && oe_hi));
  p_no_drive_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || oe_n) |-> (!oe_lo && !oe_hi));
endmodule

// File: rtl/lane_write_cap.sv
module lane_write_cap
  import card_lane_pkg::*;
#(
  parameter int  LANE_W      = 8,
  parameter bit  ATTR_FITTED = 1'b1,
  localparam int WORD_W      = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_rise,
  input  bus_mode_e         mode,
  input  logic              oe_n,
  input  logic              reg_n,
  input  logic              a0,
  input  logic [WORD_W-1:0] din,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_attr,
  output logic [1:0]        wr_strb,
  output logic [WORD_W-1:0] wr_data
);
  logic              take;
  logic [1:0]        strb_n;
  logic [WORD_W-1:0] data_n;
  logic [LANE_W-1:0] lo, hi;

  assign lo = din[LANE_W-1:0];
  assign hi = din[WORD_W-1:LANE_W];

  always_comb begin
    strb_n = 2'b00;
    data_n = {lo, lo};
    if (reg_n) begin
      unique case (mode)
        MODE_NARROW: strb_n = a0 ? 2'b10 : 2'b01;
        MODE_WIDE:   begin strb_n = 2'b11; data_n = {hi, lo}; end
        MODE_UPPER:  begin strb_n = 2'b10; data_n = {hi, hi}; end
        default:     strb_n = 2'b00;
      endcase
    end else if (ATTR_FITTED) begin
      if (mode == MODE_WIDE || (mode == MODE_NARROW && !a0)) strb_n = 2'b01;
    end
  end

  assign take = we_rise && oe_n && (strb_n != 2'b00) && !(wr_valid && !wr_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_attr  <= 1'b0;
      wr_strb  <= 2'b00;
      wr_data  <= '0;
    end else if (take) begin
      wr_valid <= 1'b1;
      wr_attr  <= !reg_n;
      wr_strb  <= strb_n;
      wr_data  <= data_n;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  p_hold_payload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_strb) && $stable(wr_attr)));
  p_attr_even_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_attr) |-> (wr_strb == 2'b01));
  p_strobe_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_strb != 2'b00));
endmodule

// File: rtl/card_lane_steer.sv
module card_lane_steer
  import card_lane_pkg::*;
#(
  parameter bit         ATTR_FITTED = 1'b1,
  parameter logic [7:0] FILL_BYTE   = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_ce1_n,
  input  logic        host_ce2_n,
  input  logic        host_reg_n,
  input  logic        host_oe_n,
  input  logic        host_we_n,
  input  logic        host_a0,
  input  logic [15:0] host_dq_in,
  output logic [15:0] host_dq_out,
  output logic        host_dq_oe_lo,
  output logic        host_dq_oe_hi,
  output logic        mem_attr_sel,
  input  logic [15:0] mem_rdata,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic        wr_attr,
  output logic [1:0]  wr_strb,
  output logic [15:0] wr_data
);
  localparam int LANE_W = 8;

  pin_sample_t smp;
  bus_mode_e   mode;
  logic        we_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp <= '{ce1_n: 1'b1, ce2_n: 1'b1, reg_n: 1'b1, oe_n: 1'b1,
               we_n: 1'b1, a0: 1'b0, data: 16'h0};
    end else begin
      smp <= '{ce1_n: host_ce1_n, ce2_n: host_ce2_n, reg_n: host_reg_n,
               oe_n: host_oe_n, we_n: host_we_n, a0: host_a0, data: host_dq_in};
    end
  end

  assign we_rise      = host_we_n && !smp.we_n;
  assign mem_attr_sel = !smp.reg_n;

  lane_mode_dec u_dec (
    .ce1_n (smp.ce1_n),
    .ce2_n (smp.ce2_n),
    .mode  (mode)
  );

  lane_read_mux #(.LANE_W(LANE_W), .ATTR_FITTED(ATTR_FITTED), .FILL_BYTE(FILL_BYTE)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .oe_n   (smp.oe_n),
    .we_n   (smp.we_n),
    .reg_n  (smp.reg_n),
    .a0     (smp.a0),
    .rdata  (mem_rdata),
    .dq_out (host_dq_out),
    .oe_lo  (host_dq_oe_lo),
    .oe_hi  (host_dq_oe_hi)
  );

  lane_write_cap #(.LANE_W(LANE_W), .ATTR_FITTED(ATTR_FITTED)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_rise  (we_rise),
    .mode     (mode),
    .oe_n     (smp.oe_n),
    .reg_n    (smp.reg_n),
    .a0       (smp.a0),
    .din      (smp.data),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_attr  (wr_attr),
    .wr_strb  (wr_strb),
    .wr_data  (wr_data)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!host_dq_oe_lo && !host_dq_oe_hi && !wr_valid));
endmodule

// File: tb/card_lane_steer_tb.sv
module card_lane_steer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, a0 = 1'b0;
  logic [15:0] dq_in = '0, rdata = 16'hA55A;
  logic wr_ready = 1'b0;

  logic [15:0] dq_out, na_dq_out, wr_data, na_wr_data;
  logic        oe_lo, oe_hi, attr_sel, wr_valid, wr_attr;
  logic        na_oe_lo, na_oe_hi, na_attr_sel, na_wr_valid, na_wr_attr;
  logic [1:0]  wr_strb, na_wr_strb;

  int n_checks = 0, n_fail = 0;

  always #10 clk = ~clk;

  card_lane_steer u_dut (
    .clk(clk), .rst_n(rst_n), .host_ce1_n(ce1_n), .host_ce2_n(ce2_n), .host_reg_n(reg_n),
    .host_oe_n(oe_n), .host_we_n(we_n), .host_a0(a0), .host_dq_in(dq_in),
    .host_dq_out(dq_out), .host_dq_oe_lo(oe_lo), .host_dq_oe_hi(oe_hi),
    .mem_attr_sel(attr_sel), .mem_rdata(rdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_attr(wr_attr), .wr_strb(wr_strb), .wr_data(wr_data));

  card_lane_steer #(.ATTR_FITTED(1'b0)) u_dut_na (
    .clk(clk), .rst_n(rst_n), .host_ce1_n(ce1_n), .host_ce2_n(ce2_n), .host_reg_n(reg_n),
    .host_oe_n(oe_n), .host_we_n(we_n), .host_a0(a0), .host_dq_in(dq_in),
    .host_dq_out(na_dq_out), .host_dq_oe_lo(na_oe_lo), .host_dq_oe_hi(na_oe_hi),
    .mem_attr_sel(na_attr_sel), .mem_rdata(rdata), .wr_valid(na_wr_valid), .wr_ready(wr_ready),
    .wr_attr(na_wr_attr), .wr_strb(na_wr_strb), .wr_data(na_wr_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive pins at a falling edge, sample after one rising edge (R12)
  task automatic set_read(input logic c1, input logic c2, input logic rg, input logic a);
    @(negedge clk);
    ce1_n = c1; ce2_n = c2; reg_n = rg; a0 = a; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic c1, input logic c2, input logic rg, input logic a,
                          input logic [15:0] d);
    @(negedge clk);
    ce1_n = c1; ce2_n = c2; reg_n = rg; a0 = a; oe_n = 1'b1; we_n = 1'b0; dq_in = d;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drain();
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 oe_lo", {31'd0, oe_lo}, 32'd0);
    check("R1 oe_hi", {31'd0, oe_hi}, 32'd0);
    check("R1 wr_valid", {31'd0, wr_valid}, 32'd0);
  endtask

  task automatic t_standby();
    set_read(1'b1, 1'b1, 1'b1, 1'b0);
    check("R2 standby enables", {30'd0, oe_hi, oe_lo}, 32'd0);
  endtask

  task automatic t_narrow();
    set_read(1'b0, 1'b1, 1'b1, 1'b0);
    check("R3 even byte", {16'd0, dq_out[7:0], 6'd0, oe_hi, oe_lo}, {16'd0, 8'h5A, 8'h01});
    check("R12 one-edge latency", {31'd0, oe_lo}, 32'd1);
    set_read(1'b0, 1'b1, 1'b1, 1'b1);
    check("R3 odd byte on low lane", {16'd0, dq_out[7:0], 6'd0, oe_hi, oe_lo}, {16'd0, 8'hA5, 8'h01});
    check("R6 single lane in 8-bit", {31'd0, oe_lo & oe_hi}, 32'd0);
  endtask

  task automatic t_wide();
    set_read(1'b0, 1'b0, 1'b1, 1'b1);
    check("R4 wide A0=1", {dq_out, 14'd0, oe_hi, oe_lo}, {16'hA55A, 16'h0003});
    set_read(1'b0, 1'b0, 1'b1, 1'b0);
    check("R4 wide A0=0", {dq_out, 14'd0, oe_hi, oe_lo}, {16'hA55A, 16'h0003});
  endtask

  task automatic t_upper();
    set_read(1'b1, 1'b0, 1'b1, 1'b0);
    check("R5 odd mode A0=0", {16'd0, dq_out[15:8], 6'd0, oe_hi, oe_lo}, {16'd0, 8'hA5, 8'h02});
    set_read(1'b1, 1'b0, 1'b1, 1'b1);
    check("R5 odd mode A0=1", {16'd0, dq_out[15:8], 6'd0, oe_hi, oe_lo}, {16'd0, 8'hA5, 8'h02});
  endtask

  task automatic t_disable();
    set_read(1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk); oe_n = 1'b1; @(negedge clk);
    check("R6 output disable", {30'd0, oe_hi, oe_lo}, 32'd0);
    oe_n = 1'b0; we_n = 1'b0; @(negedge clk);
    check("R6 no drive while WE low", {30'd0, oe_hi, oe_lo}, 32'd0);
    we_n = 1'b1; oe_n = 1'b1; @(negedge clk);
    drain();
  endtask

  task automatic t_attr_read();
    set_read(1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 attr even", {24'd0, dq_out[7:0]}, 32'h5A);
    check("R7 attr select", {31'd0, attr_sel}, 32'd1);
    check("R8 absent attr even", {24'd0, na_dq_out[7:0]}, 32'hFF);
    set_read(1'b0, 1'b1, 1'b0, 1'b1);
    check("R7 attr odd address fill", {24'd0, dq_out[7:0]}, 32'hFF);
    set_read(1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 attr wide", {16'd0, dq_out}, 32'hFF5A);
    check("R8 absent attr wide", {16'd0, na_dq_out}, 32'hFFFF);
  endtask

  task automatic t_write_common();
    do_write(1'b0, 1'b1, 1'b1, 1'b1, 16'h123C);
    check("R9 narrow odd write", {wr_data, 11'd0, wr_attr, wr_strb, 1'b0, wr_valid},
          {16'h3C3C, 16'h0009});
    check("R12 write latency", {31'd0, wr_valid}, 32'd1);
    drain();
    check("R11 drained", {31'd0, wr_valid}, 32'd0);
    do_write(1'b0, 1'b1, 1'b1, 1'b0, 16'h1244);
    check("R9 narrow even write", {wr_data, 14'd0, wr_strb}, {16'h4444, 16'h0001});
    drain();
    do_write(1'b0, 1'b0, 1'b1, 1'b1, 16'hBEEF);
    check("R9 wide write", {wr_data, 14'd0, wr_strb}, {16'hBEEF, 16'h0003});
    drain();
    do_write(1'b1, 1'b0, 1'b1, 1'b0, 16'h7701);
    check("R9 odd-mode write", {wr_data, 14'd0, wr_strb}, {16'h7777, 16'h0002});
    drain();
  endtask

  task automatic t_write_attr();
    do_write(1'b0, 1'b0, 1'b0, 1'b1, 16'h9966);
    check("R10 attr wide write", {wr_data, 13'd0, wr_attr, wr_strb}, {16'h6666, 16'h0005});
    check("R10 absent attr write dropped", {31'd0, na_wr_valid}, 32'd0);
    drain();
    do_write(1'b0, 1'b1, 1'b0, 1'b1, 16'h0011);
    check("R10 attr odd address dropped", {31'd0, wr_valid}, 32'd0);
    do_write(1'b1, 1'b0, 1'b0, 1'b0, 16'h2200);
    check("R10 attr odd mode dropped", {31'd0, wr_valid}, 32'd0);
  endtask

  task automatic t_backpressure();
    do_write(1'b0, 1'b0, 1'b1, 1'b0, 16'hCAFE);
    do_write(1'b0, 1'b0, 1'b1, 1'b0, 16'h5555);
    check("R11 payload held", {wr_data, 15'd0, wr_valid}, {16'hCAFE, 16'h0001});
    drain();
    check("R11 second edge dropped", {31'd0, wr_valid}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_standby();
    t_narrow();
    t_wide();
    t_upper();
    t_disable();
    t_attr_read();
    t_write_common();
    t_write_attr();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule